// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the bus engine of an I2C master. Software steers it with one-shot command bits, one per bus event: a Start, a Repeated Start, a Stop, the reception of one byte, and an acknowledge pulse after a received byte. Writing the transmit buffer while the engine is idle sends one byte and samples the slave's reply. Each command bit reads back as pending while its event runs, and the hardware clears it when the event completes.

SCL and SDA are open-drain lines. The block only pulls them low through output enables and reads SDA back through a synchronizer. A fixed divider sets the length of each half SCL period. The engine accepts one event at a time. While it is busy, command writes are dropped and buffer writes are refused and flagged, so nothing can be queued behind a running event.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset `busy`, `done`, `wcol`, `ack_status`, `ack_value` and `cmd_pend` are 0, and both `scl_oe` and `sda_oe` are 0 (lines released).
- R2: Control word bit 0 (Start) pulls SDA low while SCL is released, then pulls SCL low. The event lasts 2 phases of DIV_HALF clocks, and `cmd_pend` bit 0 is set until it completes.
- R3: Control word bit 1 (Repeated Start) runs four phases: SCL low with SDA released, SCL released, SDA pulled low, SCL pulled low. It lasts 4 phases and `cmd_pend` bit 1 is shown while it runs.
- R4: Control word bit 2 (Stop) runs three phases: SCL low with SDA low, SCL released, SDA released. Both lines are released at completion and `cmd_pend` bit 2 is shown while it runs.
- R5: A buffer write while idle shifts out DATA_W bits MSB first, one bit per SCL pulse, then releases SDA for a ninth pulse. The event lasts 2*DATA_W+2 phases, and SDA never changes while SCL is released.
- R6: `ack_status` takes the SDA level sampled at the end of the ninth SCL high phase: 0 means the slave acknowledged, 1 means it did not.
- R7: Control word bit 3 (receive) keeps SDA released, samples DATA_W bits MSB first at the end of each SCL high phase and presents them on `rx_data`. It lasts 2*DATA_W phases and `cmd_pend` bit 3 is shown while it runs.
- R8: Control word bit 4 (acknowledge sequence) drives the stored acknowledge value for one SCL pulse (0 pulls SDA low = ACK, 1 releases = NACK). Control word bit 5 writes that value whenever the control write is accepted. `cmd_pend` bit 4 is shown while it runs.
- R9: While `busy` is high, control writes are ignored: `cmd_pend` stays unchanged and no further event starts. When several command bits are set at once, the lowest-numbered one is taken.
- R10: A buffer write while busy is not sent and sets `wcol`. The `wcol_clr` input clears it, and a new collision in the same cycle wins.
- R11: `done` pulses high for exactly one clock in the cycle after the last phase ends, and `busy` falls on that same edge.
- R12: An accepted control write and a buffer write in the same idle cycle start the command only; the buffer write is refused and sets `wcol`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word: bits 0..4 commands, bit 5 acknowledge value |
| tx_we | input | 1 | Transmit buffer write strobe |
| tx_data | input | DATA_W | Byte to transmit |
| wcol_clr | input | 1 | Clears the write collision flag |
| sda_in | input | 1 | SDA line level |
| cmd_pend | output | 5 | Pending command bits, cleared by hardware |
| ack_value | output | 1 | Stored acknowledge value to send |
| ack_status | output | 1 | Slave response to last transmitted byte |
| rx_data | output | DATA_W | Last received byte |
| busy | output | 1 | Engine running a bus event |
| done | output | 1 | One-clock completion pulse |
| wcol | output | 1 | Write collision flag |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
Acceptance of a command and acceptance of a buffer write compete in one cycle. The bench provokes this by raising `ctl_we` with a Stop and `tx_we` on the same idle edge. It judges the result by the busy length of a Stop rather than a byte, by the Stop bit in `cmd_pend`, and by `wcol` being set. The same pair is also raised mid-byte, where both must be refused. That case is checked by the scoreboard seeing no extra byte on the wire, by `cmd_pend` holding still, and by `wcol` rising.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_START  = 3'd1,
    OP_RSTART = 3'd2,
    OP_STOP   = 3'd3,
    OP_RX     = 3'd4,
    OP_ACK    = 3'd5,
    OP_TX     = 3'd6
  } op_e;

  localparam int CMD_W  = 5;
  localparam int CTL_W  = 6;
  localparam int ACKV_BIT = 5;

  function automatic logic [CMD_W-1:0] pend_mask(op_e o);
    case (o)
      OP_START:  pend_mask = 5'b00001;
      OP_RSTART: pend_mask = 5'b00010;
      OP_STOP:   pend_mask = 5'b00100;
      OP_RX:     pend_mask = 5'b01000;
      OP_ACK:    pend_mask = 5'b10000;
      default:   pend_mask = 5'b00000;
    endcase
  endfunction

endpackage

// File: rtl/i2c_half_tick.sv
module i2c_half_tick #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_data;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/i2c_ctl_gate.sv
module i2c_ctl_gate
  import i2c_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             tx_we,
  input  logic             wcol_clr,
  output op_e              req_op,
  output logic             tx_go,
  output logic             ack_now,
  output logic             ack_val,
  output logic             wcol
);
  logic ctl_ok, cmd_ok, collide;
  op_e  cmd_op;

  assign ctl_ok  = ctl_we && !busy;
  assign cmd_ok  = ctl_ok && (|ctl_wdata[CMD_W-1:0]);
  assign tx_go   = tx_we && !busy && !cmd_ok;
  assign collide = tx_we && (busy || cmd_ok);
  assign ack_now = ctl_ok ? ctl_wdata[ACKV_BIT] : ack_val;

  always_comb begin
    if      (ctl_wdata[0]) cmd_op = OP_START;
    else if (ctl_wdata[1]) cmd_op = OP_RSTART;
    else if (ctl_wdata[2]) cmd_op = OP_STOP;
    else if (ctl_wdata[3]) cmd_op = OP_RX;
    else if (ctl_wdata[4]) cmd_op = OP_ACK;
    else                   cmd_op = OP_NONE;
  end

  always_comb begin
    if (cmd_ok)     req_op = cmd_op;
    else if (tx_go) req_op = OP_TX;
    else            req_op = OP_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_val <= 1'b0;
      wcol    <= 1'b0;
    end else begin
      if (ctl_ok) ack_val <= ctl_wdata[ACKV_BIT];
      if (collide)       wcol <= 1'b1;
      else if (wcol_clr) wcol <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_seq_pkg::*;
#(
  parameter int DIV_HALF    = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [5:0]        ctl_wdata,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              wcol_clr,
  input  logic              sda_in,
  output logic [4:0]        cmd_pend,
  output logic              ack_value,
  output logic              ack_status,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              done,
  output logic              wcol,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int PH_W    = $clog2(2 * DATA_W + 2);
  localparam int TX_LAST = 2 * DATA_W + 1;
  localparam int RX_LAST = 2 * DATA_W - 1;

  // SDA input synchronizer
  logic [SYNC_STAGES-1:0] sync_q;
  logic sda_s;
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b1;
          else     sync_q[0] <= sda_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[gi] <= 1'b1;
          else     sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate
  assign sda_s = sync_q[SYNC_STAGES-1];

  // line levels {scl, sda} for one phase of an event (1 = released)
  function automatic logic [1:0] bus_lv(op_e o, logic [PH_W-1:0] p, logic b, logic a);
    case (o)
      OP_START:  bus_lv = (p == PH_W'(0)) ? 2'b10 : 2'b00;
      OP_RSTART: begin
        if      (p == PH_W'(0)) bus_lv = 2'b01;
        else if (p == PH_W'(1)) bus_lv = 2'b11;
        else if (p == PH_W'(2)) bus_lv = 2'b10;
        else                    bus_lv = 2'b00;
      end
      OP_STOP: begin
        if      (p == PH_W'(0)) bus_lv = 2'b00;
        else if (p == PH_W'(1)) bus_lv = 2'b10;
        else                    bus_lv = 2'b11;
      end
      OP_TX:   bus_lv = {p[0], (p >= PH_W'(2 * DATA_W)) ? 1'b1 : b};
      OP_RX:   bus_lv = {p[0], 1'b1};
      OP_ACK:  bus_lv = {p[0], a};
      default: bus_lv = 2'b11;
    endcase
  endfunction

  function automatic logic [PH_W-1:0] last_ph(op_e o);
    case (o)
      OP_START:  last_ph = PH_W'(1);
      OP_RSTART: last_ph = PH_W'(3);
      OP_STOP:   last_ph = PH_W'(2);
      OP_TX:     last_ph = PH_W'(TX_LAST);
      OP_RX:     last_ph = PH_W'(RX_LAST);
      OP_ACK:    last_ph = PH_W'(1);
      default:   last_ph = '0;
    endcase
  endfunction

  op_e              req_op, op_q;
  logic             tx_go, ack_now, ack_val;
  logic             busy_q, done_q, tick;
  logic [PH_W-1:0]  ph_q;
  logic             scl_lv, sda_lv;
  logic [4:0]       pend_q;
  logic             ack_st_q;
  logic [DATA_W-1:0] rx_q, sh_q;
  logic             shift_en, at_last, next_bit, pulse_op;

  i2c_ctl_gate u_ctl (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy_q),
    .ctl_we   (ctl_we),
    .ctl_wdata(ctl_wdata),
    .tx_we    (tx_we),
    .wcol_clr (wcol_clr),
    .req_op   (req_op),
    .tx_go    (tx_go),
    .ack_now  (ack_now),
    .ack_val  (ack_val),
    .wcol     (wcol)
  );

  i2c_half_tick #(.HALF(DIV_HALF)) u_div (
    .clk (clk),
    .rst (rst),
    .run (busy_q),
    .tick(tick)
  );

  assign pulse_op = (op_q == OP_TX) || (op_q == OP_RX) || (op_q == OP_ACK);
  assign shift_en = busy_q && tick && ph_q[0] && ((op_q == OP_TX) || (op_q == OP_RX));
  assign at_last  = (ph_q == last_ph(op_q));
  assign next_bit = ph_q[0] ? sh_q[DATA_W-2] : sh_q[DATA_W-1];

  i2c_byte_shift #(.W(DATA_W)) u_sh (
    .clk      (clk),
    .rst      (rst),
    .load     (tx_go),
    .load_data(tx_data),
    .shift    (shift_en),
    .sin      (sda_s),
    .q        (sh_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      op_q     <= OP_NONE;
      ph_q     <= '0;
      scl_lv   <= 1'b1;
      sda_lv   <= 1'b1;
      pend_q   <= '0;
      ack_st_q <= 1'b0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_op != OP_NONE) begin
          busy_q <= 1'b1;
          op_q   <= req_op;
          ph_q   <= '0;
          pend_q <= pend_mask(req_op);
          {scl_lv, sda_lv} <= bus_lv(req_op, '0, tx_data[DATA_W-1], ack_now);
        end
      end else if (tick) begin
        if (at_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pend_q <= '0;
          if (pulse_op)       scl_lv   <= 1'b0;
          if (op_q == OP_TX)  ack_st_q <= sda_s;
          if (op_q == OP_RX)  rx_q     <= {sh_q[DATA_W-2:0], sda_s};
        end else begin
          ph_q <= ph_q + PH_W'(1);
          {scl_lv, sda_lv} <= bus_lv(op_q, ph_q + PH_W'(1), next_bit, ack_val);
        end
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign cmd_pend   = pend_q;
  assign ack_value  = ack_val;
  assign ack_status = ack_st_q;
  assign rx_data    = rx_q;
  assign scl_oe     = ~scl_lv;
  assign sda_oe     = ~sda_lv;
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk
  import i2c_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       tx_we,
  input logic       busy,
  input logic       done,
  input logic       wcol,
  input logic [4:0] cmd_pend,
  input op_e        op,
  input logic       scl_oe,
  input logic       sda_oe
);
  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_busy_fall_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_pend_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_pend));
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(cmd_pend));
  p_wcol_busy_r10: assert property (@(posedge clk) disable iff (rst)
    tx_we && busy |=> wcol);
  p_sda_steady_r5: assert property (@(posedge clk) disable iff (rst)
    busy && (op == OP_TX || op == OP_RX || op == OP_ACK) && !scl_oe && $past(!scl_oe)
    |-> $stable(sda_oe));
  p_rx_release_r7: assert property (@(posedge clk) disable iff (rst)
    busy && op == OP_RX |-> !sda_oe);
  p_stop_idle_r4: assert property (@(posedge clk) disable iff (rst)
    done && op == OP_STOP |-> !scl_oe && !sda_oe);
  p_start_end_r2: assert property (@(posedge clk) disable iff (rst)
    done && op == OP_START |-> scl_oe && sda_oe);
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .tx_we   (tx_we),
  .busy    (busy),
  .done    (done),
  .wcol    (wcol),
  .cmd_pend(cmd_pend),
  .op      (op_q),
  .scl_oe  (scl_oe),
  .sda_oe  (sda_oe)
);

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb;
  localparam int HALF = 4;
  localparam int DW   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic tx_we = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic wcol_clr = 1'b0;
  logic sda_in;
  logic [4:0] cmd_pend;
  logic ack_value, ack_status, busy, done, wcol, scl_oe, sda_oe;
  logic [DW-1:0] rx_data;

  always #2 clk = ~clk;

  // slave model
  logic ack_pull = 1'b0;
  logic rx_mode = 1'b0;
  logic [7:0] rx_byte = '0;
  int   rx_idx = 0;
  logic slave_pull;
  assign slave_pull = rx_mode ? ((rx_idx < 8) ? ~rx_byte[7 - rx_idx] : 1'b0) : ack_pull;
  assign sda_in = !(sda_oe || slave_pull);

  i2c_cmd_master #(.DIV_HALF(HALF), .DATA_W(DW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .tx_we(tx_we),
    .tx_data(tx_data), .wcol_clr(wcol_clr), .sda_in(sda_in), .cmd_pend(cmd_pend),
    .ack_value(ack_value), .ack_status(ack_status), .rx_data(rx_data), .busy(busy),
    .done(done), .wcol(wcol), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard for transmitted bytes
  logic [7:0] exp_q[$];
  bit   tx_active = 0;
  logic prev_scl_oe = 1'b0;
  int   mbits = 0;
  logic [7:0] mbyte = '0;

  always @(negedge clk) begin
    if (rx_mode && !prev_scl_oe && scl_oe) rx_idx++;
    if (!tx_active) mbits = 0;
    else if (prev_scl_oe && !scl_oe) begin
      mbits++;
      if (mbits <= 8) mbyte = {mbyte[6:0], ~sda_oe};
      if (mbits == 8) begin
        if (exp_q.size() == 0) chk(0, "R5", "unexpected byte", mbyte, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(mbyte == e, "R5", "byte on wire MSB first", mbyte, e);
        end
      end
      if (mbits == 9) begin
        chk(!sda_oe, "R5", "ninth pulse SDA released", sda_oe, 0);
        mbits = 0;
      end
    end
    prev_scl_oe = scl_oe;
  end

  // results of the last run
  int   r_len;
  logic r_first_scl, r_first_sda, r_hi_sda, r_any_sda, r_pend_moved, r_done;
  logic [4:0] r_pend;

  task automatic run(input logic [5:0] cw, input bit do_ctl, input logic [7:0] txd,
                     input bit do_tx, input bit poke);
    @(negedge clk);
    ctl_we = do_ctl; ctl_wdata = cw; tx_we = do_tx; tx_data = txd;
    @(negedge clk);
    ctl_we = 0; tx_we = 0;
    r_first_scl = scl_oe; r_first_sda = sda_oe; r_pend = cmd_pend;
    r_len = 0; r_hi_sda = 0; r_any_sda = 0; r_pend_moved = 0;
    while (busy && r_len < 2000) begin
      r_len++;
      if (!scl_oe) r_hi_sda = sda_oe;
      if (sda_oe) r_any_sda = 1;
      if (cmd_pend != r_pend) r_pend_moved = 1;
      if (poke && r_len == 5) begin
        ctl_we = 1; ctl_wdata = 6'h01; tx_we = 1; tx_data = 8'hFF;
      end else begin
        ctl_we = 0; tx_we = 0;
      end
      @(negedge clk);
    end
    ctl_we = 0; tx_we = 0;
    r_done = done;
    chk(r_done, "R11", "done at busy fall", r_done, 1);
    chk(cmd_pend == 5'b0, "R9", "pending cleared at completion", cmd_pend, 0);
    @(negedge clk);
    chk(!done, "R11", "done lasts one clock", done, 0);
  endtask

  task automatic clear_wcol();
    @(negedge clk); wcol_clr = 1;
    @(negedge clk); wcol_clr = 0;
    chk(!wcol, "R10", "wcol cleared", wcol, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1", "busy/done idle", {busy, done}, 0);
    chk(!scl_oe && !sda_oe, "R1", "lines released", {scl_oe, sda_oe}, 0);
    chk(cmd_pend == 0 && !wcol && !ack_status && !ack_value, "R1", "status clear",
        {cmd_pend, wcol, ack_status, ack_value}, 0);

    // R2 start
    run(6'h01, 1, 8'h00, 0, 0);
    chk(r_len == 2 * HALF, "R2", "start length", r_len, 2 * HALF);
    chk(r_pend == 5'h01, "R2", "start pending bit", r_pend, 1);
    chk(!r_first_scl && r_first_sda, "R2", "SDA low while SCL high", {r_first_scl, r_first_sda}, 1);
    chk(scl_oe && sda_oe, "R2", "SCL pulled low after start", {scl_oe, sda_oe}, 3);

    // R5/R6/R9/R10 byte with ack, pokes while busy
    ack_pull = 1; tx_active = 1; exp_q.push_back(8'hA5);
    run(6'h00, 0, 8'hA5, 1, 1);
    tx_active = 0; ack_pull = 0;
    chk(r_len == (2 * DW + 2) * HALF, "R5", "byte length", r_len, (2 * DW + 2) * HALF);
    chk(ack_status == 0, "R6", "slave acked", ack_status, 0);
    chk(!r_pend_moved && r_pend == 0, "R9", "busy command write ignored", r_pend_moved, 0);
    chk(wcol, "R10", "busy buffer write flagged", wcol, 1);
    repeat (3) @(negedge clk);
    chk(!busy, "R9", "no event started by ignored write", busy, 0);
    clear_wcol();

    // R6 nack
    tx_active = 1; exp_q.push_back(8'h3C);
    run(6'h00, 0, 8'h3C, 1, 0);
    tx_active = 0;
    chk(ack_status == 1, "R6", "slave nacked", ack_status, 1);

    // R3 repeated start
    run(6'h02, 1, 8'h00, 0, 0);
    chk(r_len == 4 * HALF, "R3", "rstart length", r_len, 4 * HALF);
    chk(r_pend == 5'h02, "R3", "rstart pending bit", r_pend, 2);
    chk(r_first_scl && !r_first_sda, "R3", "first phase SCL low SDA released", {r_first_scl, r_first_sda}, 2);
    chk(scl_oe && sda_oe, "R3", "ends with both low", {scl_oe, sda_oe}, 3);

    // R7 receive then R8 ack
    rx_byte = 8'h96; rx_idx = 0; rx_mode = 1;
    run(6'h08, 1, 8'h00, 0, 0);
    rx_mode = 0;
    chk(r_len == 2 * DW * HALF, "R7", "receive length", r_len, 2 * DW * HALF);
    chk(r_pend == 5'h08, "R7", "receive pending bit", r_pend, 8);
    chk(rx_data == 8'h96, "R7", "received byte", rx_data, 8'h96);
    chk(!r_any_sda, "R7", "SDA released during receive", r_any_sda, 0);
    run(6'h10, 1, 8'h00, 0, 0);
    chk(r_len == 2 * HALF && r_pend == 5'h10, "R8", "ack sequence length/pending", r_len, 2 * HALF);
    chk(r_hi_sda == 1, "R8", "ACK pulls SDA low", r_hi_sda, 1);
    chk(ack_value == 0, "R8", "stored ack value", ack_value, 0);

    rx_byte = 8'h5A; rx_idx = 0; rx_mode = 1;
    run(6'h08, 1, 8'h00, 0, 0);
    rx_mode = 0;
    chk(rx_data == 8'h5A, "R7", "second received byte", rx_data, 8'h5A);
    run(6'h30, 1, 8'h00, 0, 0);
    chk(r_hi_sda == 0, "R8", "NACK releases SDA", r_hi_sda, 0);
    chk(ack_value == 1, "R8", "stored nack value", ack_value, 1);

    // R12 stop and buffer write in the same idle cycle
    tx_active = 1;
    run(6'h04, 1, 8'hC3, 1, 0);
    tx_active = 0;
    chk(r_len == 3 * HALF, "R12", "stop taken, byte refused", r_len, 3 * HALF);
    chk(r_pend == 5'h04, "R4", "stop pending bit", r_pend, 4);
    chk(wcol, "R12", "same-cycle buffer write flagged", wcol, 1);
    chk(!scl_oe && !sda_oe, "R4", "bus released after stop", {scl_oe, sda_oe}, 0);
    clear_wcol();

    // R9 priority: lowest command bit wins
    run(6'h06, 1, 8'h00, 0, 0);
    chk(r_pend == 5'h02 && r_len == 4 * HALF, "R9", "priority picks repeated start", r_pend, 2);
    run(6'h04, 1, 8'h00, 0, 0);
    chk(!scl_oe && !sda_oe, "R4", "final stop releases bus", {scl_oe, sda_oe}, 0);

    chk(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule